// File: doc/BRIEF.md
# Per-Input Interrupt Condition Capture

This block turns a vector of raw interrupt lines into sticky condition bits, one per line. Each line is configured at elaboration time by three parameter vectors: whether it is edge or level sensitive, which edge (rising or falling) counts for an edge line, and which level (high or low) counts for a level line. Raw lines may change with no fixed relation to the block clock. Edge lines pass through a two-stage synchronizer before edge detection. Level lines are sampled directly into the condition flop.

A captured condition stays set until the matching bit of the acknowledge vector is pulsed. A mode input picks the source of new conditions. When it is high, the hardware lines are the source. When it is low, only the software-set vector can raise a condition, and a software request needs no particular type or polarity. The condition vector drives downstream masking, request generation and vector encoding, none of which sit in this block. All pins are plain control and status signals. The block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `intc_capture`

## Requirements
- R1: While `rst_n` is low, `cond` is all zeros.
- R2: An edge line (`EDGE_SEL` bit = 1) captures a condition on its active edge. The active edge is rising when its `EDGE_RISE` bit is 1 and falling when it is 0. If the line changes between clock edges k-1 and k, the bit of `cond` reads 1 after clock edge k+2.
- R3: An edge line that stays at its active level after an acknowledge raises no new condition. It must go inactive and then active again to capture again.
- R4: A level line (`EDGE_SEL` bit = 0) with hardware mode on captures on every clock edge where it is at its active level. The active level is high when its `LVL_HIGH` bit is 1 and low when it is 0. The bit reads 1 after that edge.
- R5: A set `cond` bit stays set until an edge at which its `ack` bit is 1 and no new capture occurs for that bit. After that edge it reads 0, and bits whose `ack` is 0 are unchanged.
- R6: When a capture and an acknowledge of the same bit fall on the same clock edge, the bit is set after that edge.
- R7: With `hw_en` = 0, hardware lines raise no condition, and an `sw_set` bit of 1 sets the matching `cond` bit at the next edge. With `hw_en` = 1, `sw_set` has no effect.
- R8: An active edge that passes through the synchronizer while `hw_en` = 0 is dropped. It is not captured when `hw_en` later returns to 1.
- R9: The synchronizer of an edge line starts at that line's inactive level. An edge line already at its active level when reset is released therefore counts as one active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N | Raw interrupt lines, may be asynchronous |
| hw_en | input | 1 | 1 = hardware lines are the source, 0 = software set is the source |
| sw_set | input | N | Software requests, honoured only while `hw_en` = 0 |
| ack | input | N | Per-bit clear of captured conditions |
| cond | output | N | Sticky captured condition bits |

## Verification
The collision that matters is a new capture and an acknowledge of the same bit on the same clock edge. This can happen through a level line held active while it is acknowledged, or through `sw_set` and `ack` raised together in software mode. Directed steps provoke both cases and expect the bit to read 1 afterwards. A long random sweep then toggles lines, acknowledges, software requests and the mode input together. It compares every cycle against a bench model built from the stated latencies and precedence. The mixed configuration covers both edge polarities and both level polarities.

// File: rtl/intc_cap_pkg.sv
package intc_cap_pkg;

  typedef enum logic {
    SRC_SW = 1'b0,
    SRC_HW = 1'b1
  } src_mode_e;

  function automatic logic is_active(input logic v, input logic pol);
    return v == pol;
  endfunction

endpackage

// File: rtl/intc_sync2.sv
module intc_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/intc_cap_lane.sv
module intc_cap_lane
  import intc_cap_pkg::*;
#(
  parameter bit IS_EDGE = 1'b1,
  parameter bit ACT_POL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic hw_en,
  input  logic sw_set,
  input  logic ack,
  output logic cond
);

  logic      hit;
  logic      cap;
  src_mode_e mode;

  generate
    if (IS_EDGE) begin : g_edge
      logic synced;
      logic prev;

      // synchronizer and history start inactive: an active line at release is one edge
      intc_sync2 #(.RST_VAL(!ACT_POL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= !ACT_POL;
        else        prev <= synced;
      end

      assign hit = is_active(synced, ACT_POL) && !is_active(prev, ACT_POL);
    end else begin : g_level
      assign hit = is_active(raw, ACT_POL);
    end
  endgenerate

  assign mode = src_mode_e'(hw_en);

  always_comb begin
    if (mode == SRC_HW) cap = hit;
    else                cap = sw_set;
  end

  // new capture takes precedence over a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond <= 1'b0;
    else        cond <= cap | (cond & ~ack);
  end

endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int            N         = 8,
  parameter logic [N-1:0]  EDGE_SEL  = '1,
  parameter logic [N-1:0]  EDGE_RISE = '1,
  parameter logic [N-1:0]  LVL_HIGH  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         hw_en,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] ack,
  output logic [N-1:0] cond
);

  localparam logic [N-1:0] ACT_POL = (EDGE_SEL & EDGE_RISE) | (~EDGE_SEL & LVL_HIGH);

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      intc_cap_lane #(
        .IS_EDGE (EDGE_SEL[g]),
        .ACT_POL (ACT_POL[g])
      ) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_in[g]),
        .hw_en  (hw_en),
        .sw_set (sw_set[g]),
        .ack    (ack[g]),
        .cond   (cond[g])
      );
    end
  endgenerate

endmodule

// File: rtl/intc_capture_chk.sv
module intc_capture_chk #(
  parameter int            N         = 8,
  parameter logic [N-1:0]  EDGE_SEL  = '1,
  parameter logic [N-1:0]  EDGE_RISE = '1,
  parameter logic [N-1:0]  LVL_HIGH  = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_in,
  input logic         hw_en,
  input logic [N-1:0] sw_set,
  input logic [N-1:0] ack,
  input logic [N-1:0] cond
);

  logic [N-1:0] lvl_act;
  logic [N-1:0] edge_act;

  assign lvl_act  = ~(irq_in ^ LVL_HIGH) & ~EDGE_SEL;
  assign edge_act = ~(irq_in ^ EDGE_RISE) & EDGE_SEL;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (cond == '0);
    end
  end

  // a hardware rise on an edge bit needs the raw line active three samples back
  assert_edge_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond & ~$past(cond) & EDGE_SEL & {N{$past(hw_en)}} & ~$past(edge_act, 3)) == '0));

  assert_level_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |=> ((~cond & $past(lvl_act)) == '0));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cond) & ~$past(ack) & ~cond) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en && ((sw_set & ack) != '0)) |=>
      ((cond & $past(sw_set & ack)) == $past(sw_set & ack)));

  assert_sw_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |=> ((cond & ~$past(cond) & ~$past(sw_set)) == '0));

endmodule

bind intc_capture intc_capture_chk #(
  .N         (N),
  .EDGE_SEL  (EDGE_SEL),
  .EDGE_RISE (EDGE_RISE),
  .LVL_HIGH  (LVL_HIGH)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_in (irq_in),
  .hw_en  (hw_en),
  .sw_set (sw_set),
  .ack    (ack),
  .cond   (cond)
);

// File: tb/intc_capture_bench.sv
`timescale 1ns/1ps
module intc_capture_bench;

  localparam int         N     = 8;
  localparam logic [7:0] ESEL  = 8'h0F;  // bits 0-3 edge, 4-7 level
  localparam logic [7:0] ERISE = 8'hF5;  // bits 0,2 rising; 1,3 falling
  localparam logic [7:0] LHIGH = 8'h5F;  // bits 4,6 high; 5,7 low
  localparam logic [7:0] IDLE  = 8'hAA;  // every line at its inactive level

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in, sw_set, ack;
  logic       hw_en;
  logic [7:0] cond;

  logic [7:0] m_cond, m_s1, m_s2, m_s3;
  int         checks = 0;
  int         fails  = 0;
  string      tag;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  intc_capture #(
    .N(N), .EDGE_SEL(ESEL), .EDGE_RISE(ERISE), .LVL_HIGH(LHIGH)
  ) u_intc_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .hw_en(hw_en),
    .sw_set(sw_set), .ack(ack), .cond(cond)
  );

  // model advances with the inputs that were present at the edge just passed
  task automatic model_and_compare();
    logic [7:0] ehit, lhit, cap;
    if (!rst_n) begin
      m_cond = '0; m_s1 = ~ERISE; m_s2 = ~ERISE; m_s3 = ~ERISE;
    end else begin
      ehit   = ~(m_s2 ^ ERISE) & (m_s3 ^ ERISE) & ESEL;
      lhit   = ~(irq_in ^ LHIGH) & ~ESEL;
      cap    = hw_en ? (ehit | lhit) : sw_set;
      m_cond = cap | (m_cond & ~ack);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    end
    checks++;
    if (cond !== m_cond) begin
      fails++;
      $display("FAIL %s: cond=%h expected %h", tag, cond, m_cond);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic [7:0] a,
                      input logic [7:0] s, input logic h);
    @(negedge clk);
    model_and_compare();
    irq_in = r; ack = a; sw_set = s; hw_en = h;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected %h", t, act, exp);
    end
  endtask

  initial begin
    logic [7:0] r, a, s;
    logic       h;
    rst_n = 1'b0; irq_in = IDLE; ack = '0; sw_set = '0; hw_en = 1'b1;
    m_cond = '0; m_s1 = ~ERISE; m_s2 = ~ERISE; m_s3 = ~ERISE;

    tag = "R1";
    repeat (3) step(IDLE, 0, 0, 1);
    chk(cond, 8'h00, "R1 reset clears");
    rst_n = 1'b1;
    repeat (3) step(IDLE, 0, 0, 1);

    tag = "R2";
    step(8'hAB, 0, 0, 1);
    step(8'hAB, 0, 0, 1);
    step(8'hAB, 0, 0, 1);
    chk(cond & 8'h01, 8'h00, "R2 not before third edge");
    step(8'hAB, 0, 0, 1);
    chk(cond & 8'h01, 8'h01, "R2 rising edge captured");

    tag = "R3";
    step(8'hAB, 8'h01, 0, 1);
    step(8'hAB, 0, 0, 1);
    repeat (4) step(8'hAB, 0, 0, 1);
    chk(cond & 8'h01, 8'h00, "R3 held line no recapture");
    step(IDLE, 0, 0, 1);
    repeat (2) step(IDLE, 0, 0, 1);
    step(8'hAB, 0, 0, 1);
    repeat (3) step(8'hAB, 0, 0, 1);
    chk(cond & 8'h01, 8'h01, "R3 new edge recaptures");
    step(8'hAB, 8'h01, 0, 1);
    step(IDLE, 0, 0, 1);

    tag = "R4";
    step(8'hBA, 0, 0, 1);
    step(8'hBA, 0, 0, 1);
    chk(cond & 8'h10, 8'h10, "R4 active-high level");
    step(8'hBA, 8'h10, 0, 1);
    step(8'hBA, 0, 0, 1);
    chk(cond & 8'h10, 8'h10, "R4 R6 level held across ack");
    step(IDLE, 8'h10, 0, 1);
    step(IDLE, 0, 0, 1);
    chk(cond & 8'h10, 8'h00, "R5 ack clears");
    step(8'h8A, 0, 0, 1);
    step(8'h8A, 0, 0, 1);
    chk(cond & 8'h20, 8'h20, "R4 active-low level");
    step(IDLE, 8'h20, 0, 1);
    step(IDLE, 0, 0, 1);
    chk(cond & 8'h20, 8'h00, "R5 ack clears low level");

    tag = "R7";
    step(IDLE, 8'hFF, 0, 0);
    step(8'hBA, 0, 0, 0);
    step(8'hBA, 0, 0, 0);
    chk(cond & 8'h10, 8'h00, "R7 hardware ignored in software mode");
    step(8'hBA, 0, 8'h80, 0);
    step(8'hBA, 0, 0, 0);
    chk(cond & 8'h80, 8'h80, "R7 software set");
    step(8'hBA, 8'h80, 8'h80, 0);
    step(8'hBA, 0, 0, 0);
    chk(cond & 8'h80, 8'h80, "R6 set beats ack");
    step(8'hBA, 8'h80, 0, 0);
    step(8'hBA, 0, 0, 0);
    chk(cond & 8'h80, 8'h00, "R5 software bit cleared");

    tag = "R8";
    step(IDLE, 0, 0, 0);
    step(8'hAE, 0, 0, 0);
    repeat (4) step(8'hAE, 0, 0, 0);
    step(8'hAE, 0, 0, 1);
    repeat (4) step(8'hAE, 0, 0, 1);
    chk(cond & 8'h04, 8'h00, "R8 edge during software mode dropped");
    step(8'hAE, 0, 8'h08, 1);
    step(8'hAE, 0, 0, 1);
    chk(cond & 8'h08, 8'h00, "R7 software set ignored in hardware mode");

    tag = "R9";
    step(8'hAB, 0, 0, 1);
    rst_n = 1'b0;
    repeat (3) step(8'hAB, 0, 0, 1);
    chk(cond, 8'h00, "R1 reset during active line");
    step(8'hAB, 0, 0, 1);
    rst_n = 1'b1;
    repeat (4) step(8'hAB, 0, 0, 1);
    chk(cond & 8'h01, 8'h01, "R9 active at release counts as edge");

    tag = "sweep R2 R3 R4 R5 R6 R7 R8";
    for (int i = 0; i < 20000; i++) begin
      r = irq_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      a = 8'($urandom) & 8'($urandom) & 8'($urandom);
      s = 8'($urandom) & 8'($urandom) & 8'($urandom);
      h = ($urandom_range(0, 63) == 0) ? ~hw_en : hw_en;
      step(r, a, s, h);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule